// File: doc/BRIEF.md
# Bridge memory and I/O window decoder

This block holds the forwarding windows of a bridge between a host bus and a card-side bus, and decides which downstream accesses the bridge claims. It has two memory windows and two I/O windows. Each window is set by a lower-bound register and an upper-bound register. Memory windows have 4 KB granularity and I/O windows have doubleword granularity. Hard-wired zero bits in the registers force this granularity. A control register holds one prefetchable flag per memory window.

Software programs the registers through a small configuration port. The port takes a dword index, byte enables and write data, and returns read data combinationally. The decode path is combinational. An access is presented as an address, a request strobe and a memory or I/O type. In the same cycle the block states whether the access is claimed, which window matched, and whether the claimed memory window is prefetchable. A window stays disabled while both of its bound registers are zero, so after reset nothing is forwarded.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset, every window register and the prefetch flags read as zero, and no access is claimed.
- R2: The memory bound registers sit at dword indexes 7 and 8 (window 0) and 9 and 10 (window 1), which are byte offsets 1Ch, 20h, 24h and 28h, lower bound first. Bits 31..12 are writable. Bits 11..0 always read zero, whatever was written to them.
- R3: The I/O bound registers sit at dword indexes 11 and 12 (window 0) and 13 and 14 (window 1), which are byte offsets 2Ch, 30h, 34h and 38h, lower bound first. Bits 31..2 are writable. Bits 1..0 always read zero.
- R4: A write updates only the bytes whose byte enable is set. `cfg_be[i]` covers data bits 8i+7..8i. A write with all enables clear changes nothing.
- R5: A memory access is claimed by a window when its address bits 31..12 lie between those of the lower and upper bound, both ends included. The top of the window is therefore the upper bound plus FFFh.
- R6: An I/O access is claimed by a window when its address bits 31..2 lie between those of the lower and upper bound, both ends included.
- R7: A window whose lower and upper bound registers are both zero claims nothing, not even address zero.
- R8: When both windows of the access type match, window 0 is reported on `dec_win`, which carries 0 or 1.
- R9: The prefetch flags are bits 24 (memory window 0) and 25 (memory window 1) of dword index 15 (offset 3Ch). All other bits of that dword read zero. `dec_prefetch` gives the flag of the claimed memory window. It is 0 for an I/O claim or when nothing is claimed.
- R10: With `dec_req` low nothing is claimed. A memory access is decoded only against memory windows and an I/O access only against I/O windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register bank |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data at `cfg_addr` (combinational) |
| dec_req | input | 1 | An access is presented for decode |
| dec_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| dec_addr | input | 32 | Address of the presented access |
| dec_claim | output | 1 | The bridge claims the access |
| dec_win | output | 1 | Index of the matching window |
| dec_prefetch | output | 1 | The claimed memory window is prefetchable |

## Verification
The bench programs the two memory windows so that they overlap, with different prefetch flags, and sets up two I/O windows in separate 64 KB pages. It then walks a table of addresses. Addresses one below each lower bound, at each bound, one past each upper bound and inside the overlap tell an exclusive limit from an inclusive one and expose a wrong priority. Swapping the access type on an address that lies in a window of the other type shows whether the memory and I/O decodes are kept apart. Directed writes with partial and empty byte enables, writes of all ones to the hard-wired bits, and a window cleared back to zero then separate correct masking and enabling from simple storage.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int DATA_W    = 32;
  localparam int BYTES     = DATA_W / 8;
  localparam logic [DATA_W-1:0] MEM_MASK = 32'hFFFF_F000;
  localparam logic [DATA_W-1:0] IO_MASK  = 32'hFFFF_FFFC;

  // merge enabled bytes of new data into old value, then clear hard-wired bits
  function automatic logic [DATA_W-1:0] be_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [BYTES-1:0]  be,
    input logic [DATA_W-1:0] mask
  );
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int i = 0; i < BYTES; i++)
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r & mask;
  endfunction

  // inclusive range test on the masked address
  function automatic logic in_range(
    input logic [DATA_W-1:0] addr,
    input logic [DATA_W-1:0] lo,
    input logic [DATA_W-1:0] hi,
    input logic [DATA_W-1:0] mask
  );
    logic [DATA_W-1:0] a;
    a = addr & mask;
    return (a >= (lo & mask)) && (a <= (hi & mask));
  endfunction
endpackage

// File: rtl/bwd_regs.sv
module bwd_regs
  import bwd_pkg::*;
#(
  parameter int NWIN    = 2,
  parameter int CFG_AW  = 6,
  parameter int MEM_DW0 = 7,
  parameter int PF_BIT0 = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [BYTES-1:0]             cfg_be,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  output logic [NWIN-1:0][DATA_W-1:0]  mem_lo,
  output logic [NWIN-1:0][DATA_W-1:0]  mem_hi,
  output logic [NWIN-1:0][DATA_W-1:0]  io_lo,
  output logic [NWIN-1:0][DATA_W-1:0]  io_hi,
  output logic [NWIN-1:0]              pf
);
  localparam int IO_DW0  = MEM_DW0 + 2*NWIN;
  localparam int CTRL_DW = IO_DW0 + 2*NWIN;
  localparam int PF_BYTE = PF_BIT0 / 8;

  logic [31:0] sel;
  assign sel = 32'(cfg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_lo <= '0;
      mem_hi <= '0;
      io_lo  <= '0;
      io_hi  <= '0;
      pf     <= '0;
    end else if (cfg_wr) begin
      for (int k = 0; k < NWIN; k++) begin
        if (sel == 32'(MEM_DW0 + 2*k))
          mem_lo[k] <= be_merge(mem_lo[k], cfg_wdata, cfg_be, MEM_MASK);
        if (sel == 32'(MEM_DW0 + 2*k + 1))
          mem_hi[k] <= be_merge(mem_hi[k], cfg_wdata, cfg_be, MEM_MASK);
        if (sel == 32'(IO_DW0 + 2*k))
          io_lo[k]  <= be_merge(io_lo[k], cfg_wdata, cfg_be, IO_MASK);
        if (sel == 32'(IO_DW0 + 2*k + 1))
          io_hi[k]  <= be_merge(io_hi[k], cfg_wdata, cfg_be, IO_MASK);
        if (sel == 32'(CTRL_DW) && cfg_be[PF_BYTE])
          pf[k] <= cfg_wdata[PF_BIT0 + k];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NWIN; k++) begin
      if (sel == 32'(MEM_DW0 + 2*k))     cfg_rdata = mem_lo[k];
      if (sel == 32'(MEM_DW0 + 2*k + 1)) cfg_rdata = mem_hi[k];
      if (sel == 32'(IO_DW0 + 2*k))      cfg_rdata = io_lo[k];
      if (sel == 32'(IO_DW0 + 2*k + 1))  cfg_rdata = io_hi[k];
    end
    if (sel == 32'(CTRL_DW))
      for (int k = 0; k < NWIN; k++) cfg_rdata[PF_BIT0 + k] = pf[k];
  end

  // named event for the stability check below
  logic idle_write;
  assign idle_write = cfg_wr && (cfg_be == '0);

  AST_MEM_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lo[0][11:0] == '0) && (mem_hi[NWIN-1][11:0] == '0)); // R2
  AST_IO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_lo[0][1:0] == '0) && (io_hi[NWIN-1][1:0] == '0)); // R3
  AST_EMPTY_BE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_write |=> ($stable(mem_lo) && $stable(mem_hi) && $stable(io_lo) && $stable(io_hi) && $stable(pf))); // R4
endmodule

// File: rtl/bwd_match.sv
module bwd_match
  import bwd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = MEM_MASK
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              en,
  output logic              hit
);
  assign en  = (lo != '0) || (hi != '0);
  assign hit = en && in_range(addr, lo, hi, MASK);
endmodule

// File: rtl/bwd_prio.sv
module bwd_prio #(
  parameter int NWIN  = 2,
  parameter int WIN_W = 1
) (
  input  logic [NWIN-1:0]  hits,
  output logic             any,
  output logic [WIN_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NWIN-1; k >= 0; k--)
      if (hits[k]) begin
        any = 1'b1;
        idx = WIN_W'(k);
      end
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int CFG_AW = 6,
  parameter int WIN_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dec_req,
  input  logic              dec_is_io,
  input  logic [31:0]       dec_addr,
  output logic              dec_claim,
  output logic [WIN_W-1:0]  dec_win,
  output logic              dec_prefetch
);
  logic [NWIN-1:0][DATA_W-1:0] mem_lo, mem_hi, io_lo, io_hi;
  logic [NWIN-1:0] pf, mem_en, mem_hit, io_en, io_hit;
  logic mem_any, io_any;
  logic [WIN_W-1:0] mem_idx, io_idx;

  bwd_regs #(.NWIN(NWIN), .CFG_AW(CFG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_lo(mem_lo), .mem_hi(mem_hi), .io_lo(io_lo), .io_hi(io_hi), .pf(pf)
  );

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    bwd_match #(.MASK(MEM_MASK)) mem_m (
      .addr(dec_addr), .lo(mem_lo[k]), .hi(mem_hi[k]),
      .en(mem_en[k]), .hit(mem_hit[k]));
    bwd_match #(.MASK(IO_MASK)) io_m (
      .addr(dec_addr), .lo(io_lo[k]), .hi(io_hi[k]),
      .en(io_en[k]), .hit(io_hit[k]));
  end

  bwd_prio #(.NWIN(NWIN), .WIN_W(WIN_W)) mem_p (.hits(mem_hit), .any(mem_any), .idx(mem_idx));
  bwd_prio #(.NWIN(NWIN), .WIN_W(WIN_W)) io_p  (.hits(io_hit),  .any(io_any),  .idx(io_idx));

  assign dec_claim    = dec_req && (dec_is_io ? io_any : mem_any);
  assign dec_win      = dec_is_io ? io_idx : mem_idx;
  assign dec_prefetch = dec_claim && !dec_is_io && pf[mem_idx];

  AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_req |-> !dec_claim); // R10
  AST_CLAIM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_claim |-> (dec_is_io ? io_en[dec_win] : mem_en[dec_win])); // R7
  AST_LOW_WINDOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_claim && !dec_is_io && mem_hit[0]) |-> (dec_win == '0)); // R8
  AST_PF_ON_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_prefetch |-> (dec_claim && !dec_is_io)); // R9
endmodule

// File: tb/bridge_window_decoder_tb_top.sv
module bridge_window_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic dec_req = 1'b0, dec_is_io = 1'b0;
  logic [31:0] dec_addr = '0;
  logic dec_claim, dec_prefetch;
  logic [0:0] dec_win;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bridge_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_req(dec_req),
    .dec_is_io(dec_is_io), .dec_addr(dec_addr), .dec_claim(dec_claim),
    .dec_win(dec_win), .dec_prefetch(dec_prefetch));

  // {req tag number[3:0], is_io, addr[31:0], claim, win, prefetch}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {4'd5, 1'b0, 32'h0FFF_FFFF, 3'b000},  // R5 just below mem0
    {4'd5, 1'b0, 32'h1000_0000, 3'b100},  // R5 mem0 lower bound
    {4'd5, 1'b0, 32'h1000_3FFF, 3'b100},  // R5 inclusive top of mem0
    {4'd8, 1'b0, 32'h1000_2500, 3'b100},  // R8 overlap, window 0 wins
    {4'd9, 1'b0, 32'h1000_4000, 3'b111},  // R9 mem1 only, prefetchable
    {4'd5, 1'b0, 32'h2000_0FFF, 3'b111},  // R5 inclusive top of mem1
    {4'd5, 1'b0, 32'h2000_1000, 3'b000},  // R5 past mem1
    {4'd10, 1'b1, 32'h1000_0000, 3'b000}, // R10 mem address as I/O
    {4'd10, 1'b0, 32'h0000_1000, 3'b000}, // R10 I/O address as memory
    {4'd6, 1'b1, 32'h0000_0FFC, 3'b000},  // R6 below io0
    {4'd6, 1'b1, 32'h0000_1000, 3'b100},  // R6 io0 lower bound
    {4'd6, 1'b1, 32'h0000_10FF, 3'b100},  // R6 last byte of io0
    {4'd6, 1'b1, 32'h0000_1100, 3'b000},  // R6 past io0
    {4'd9, 1'b1, 32'h0001_0100, 3'b110},  // R9 io1 claim, no prefetch
    {4'd6, 1'b1, 32'h0001_0203, 3'b110},  // R6 last byte of io1
    {4'd6, 1'b1, 32'h0001_0204, 3'b000}   // R6 past io1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = 6'(dw); cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input int dw, input logic [31:0] exp);
    cfg_addr = 6'(dw);
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic dec(input string tag, input logic req, input logic io,
                     input logic [31:0] a, input logic [2:0] exp);
    dec_req = req; dec_is_io = io; dec_addr = a;
    #1;
    check(tag, {29'd0, dec_claim, dec_win, dec_prefetch}, {29'd0, exp});
  endtask

  initial begin
    #(8*100000);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int dw = 7; dw <= 15; dw++) rd("R1 reset read", dw, 32'h0);
    dec("R1 reset mem no claim", 1'b1, 1'b0, 32'h0000_0000, 3'b000);
    dec("R7 reset io zero no claim", 1'b1, 1'b1, 32'h0000_0000, 3'b000);
    // R2 hard-wired low bits of memory bounds
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd("R2 mem all ones", 8, 32'hFFFF_F000);
    wr(8, 4'hF, 32'h1000_3ABC);
    rd("R2 mem low cleared", 8, 32'h1000_3000);
    // R3 hard-wired low bits of I/O bounds
    wr(12, 4'hF, 32'h0000_10FF);
    rd("R3 io low cleared", 12, 32'h0000_10FC);
    // R4 byte enables
    wr(11, 4'b0001, 32'hFFFF_10AB);
    rd("R4 byte0 only", 11, 32'h0000_00A8);
    wr(11, 4'b0010, 32'h0000_1000);
    rd("R4 byte1 only", 11, 32'h0000_10A8);
    wr(11, 4'hF, 32'h0000_1000);
    wr(11, 4'b0000, 32'hFFFF_FFFF);
    rd("R4 no enables", 11, 32'h0000_1000);
    // remaining configuration
    wr(7, 4'hF, 32'h1000_0000);
    wr(9, 4'hF, 32'h1000_2000);
    wr(10, 4'hF, 32'h2000_0000);
    wr(13, 4'hF, 32'h0001_0100);
    wr(14, 4'hF, 32'h0001_0200);
    wr(15, 4'hF, 32'hFFFF_FFFF);
    rd("R9 ctrl only flags", 15, 32'h0300_0000);
    wr(15, 4'b0111, 32'h0000_0000);
    rd("R9 ctrl byte3 disabled", 15, 32'h0300_0000);
    wr(15, 4'b1000, 32'h0200_0000);
    rd("R9 ctrl window1 flag", 15, 32'h0200_0000);
    // table walk
    foreach (VEC[i])
      dec($sformatf("R%0d vector %0d", VEC[i][39:36], i), 1'b1, VEC[i][35],
          VEC[i][34:3], VEC[i][2:0]);
    // R10 request low
    dec("R10 req low", 1'b0, 1'b0, 32'h1000_0000, 3'b000);
    // R7 window cleared back to zero
    wr(7, 4'hF, 32'h0);
    wr(8, 4'hF, 32'h0);
    dec("R7 cleared mem0 addr 0", 1'b1, 1'b0, 32'h0000_0800, 3'b000);
    dec("R7 cleared mem0 old addr", 1'b1, 1'b0, 32'h1000_0000, 3'b000);
    dec("R5 mem1 still claims", 1'b1, 1'b0, 32'h1000_2000, 3'b111);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule